// File: doc/BRIEF.md
# Shared-Bus Transfer Sequencer

This block is the control engine that moves data words, one bus cycle at a time, between a local processing engine and a shared memory reached over an arbitrated bus. A host processor arms it at the start of every processing pass by strobing a control word into it. The control word gives the direction of the pass (read from memory or write to memory) and the number of words to move. The sequencer then raises a bus request and waits for the memory grant. For a read, it captures the bus data into a local read register on the memory's data strobe. For a write, it drives the word held in its write register onto the bus and pulls the active-low write line.

A bus cycle ends only when memory withdraws its grant. At that point the address-valid, data-drive and write lines fall together. The sequencer then pulses an address-advance strobe for an external address generator. Before it starts the next cycle, it waits for a port-access acknowledge from the host, which confirms that the host has taken the read word or has supplied the next write word. When the programmed count is used up, the sequencer parks in a done state.

If the host strobes a new control word while a cycle is in flight, the current pass is aborted. The request is dropped at once, without waiting for the grant, and a new pass begins. Every output comes straight from a flip-flop.

Top module: `gbus_xfer_seq`

## Requirements
- R1: While synchronous reset is high, and on the first clock after it, bus_req, bus_addr_en, bus_drive, addr_step, done and busy are 0 and bus_wr_n is 1.
- R2: A ctl_load pulse with a nonzero ctl_count starts a pass. On the first clock after the load, busy is 1 and bus_req is 0. On the second clock after the load, bus_req is 1 and bus_addr_en is 1.
- R3: bus_req stays high until the clock edge that samples bus_grant high, and it is low from the clock that follows. bus_addr_en stays high for as long as the grant is held.
- R4: In a read pass (ctl_dir = 0), bus_wr_n stays 1 and bus_drive stays 0. rd_word takes bus_rdata at a clock edge where bus_strobe is high during the cycle, and the word is readable when addr_step pulses.
- R5: In a write pass (ctl_dir = 1), bus_drive is 1 and bus_wr_n is 0 during every bus cycle. Each cycle carries the write-register word on bus_wdata.
- R6: One clock after the edge that samples bus_grant low, bus_addr_en and bus_drive fall and bus_wr_n returns to 1, all in the same clock. In that same clock, addr_step is high for exactly one cycle.
- R7: After each addr_step of a pass that is not yet complete, bus_req stays low until a host_ack pulse is sampled. The request rises on the clock after that sample.
- R8: After ctl_count completed cycles, done rises on the clock after the last addr_step. busy falls at the same time, and no further request is made until the next ctl_load. addr_step pulses exactly ctl_count times.
- R9: A ctl_load pulse with ctl_count = 0 sets done on the next clock and issues no bus request.
- R10: A ctl_load pulse while a request is pending aborts that cycle. On the next clock, bus_req and bus_addr_en are 0 whatever the grant is doing, and the new pass then starts as in R2.
- R11: The write register loads host_wdata at a ctl_load pulse and at a host_ack pulse taken while the sequencer waits for the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_load | input | 1 | Host strobe that loads the control word and starts (or restarts) a pass |
| ctl_dir | input | 1 | Direction of the pass: 0 = read from memory, 1 = write to memory |
| ctl_count | input | CNT_W | Number of words to transfer in the pass |
| host_ack | input | 1 | Host port-access acknowledge: the read word has been taken or the next write word is ready |
| host_wdata | input | DATA_W | Next word to be written, from the host |
| bus_grant | input | 1 | Memory grant; its removal ends the bus cycle |
| bus_strobe | input | 1 | Memory data strobe for reads |
| bus_rdata | input | DATA_W | Read data from the shared bus |
| bus_req | output | 1 | Bus request |
| bus_addr_en | output | 1 | Address-valid, held for the whole bus cycle |
| bus_drive | output | 1 | Write-data drive enable |
| bus_wr_n | output | 1 | Read/write line; low means write |
| bus_wdata | output | DATA_W | Write-register contents |
| rd_word | output | DATA_W | Read-register contents |
| addr_step | output | 1 | One-clock pulse that advances the external address generator |
| done | output | 1 | Pass complete |
| busy | output | 1 | Pass in progress |

## Verification
The bench builds the block with DATA_W = 16 and CNT_W = 4. With the narrow count field, the largest legal count (15, all ones) can be run as a full pass, so the counter's top value is exercised alongside single-word and zero-word passes. The modelled memory adds a random 0 to 7 clocks before granting and holds the grant for a random 1 to 3 clocks. The host waits a random 1 to 4 clocks before acknowledging. These random delays move the grant edges and host acknowledges around the state machine's waiting states. Both directions are run, back to back from the done state, and an abort is forced while a request is pending with the memory model silenced.

// File: rtl/gxs_pkg.sv
package gxs_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE,     // after reset, nothing programmed
        S_ARM,      // control word taken, request follows
        S_CYC,      // request out, waiting for grant
        S_GNT,      // granted, waiting for grant removal
        S_POST,     // cycle closed, address advance
        S_HOST,     // waiting for host port access
        S_DONE      // count exhausted
    } seq_state_t;

    // Registered bus-side control outputs
    typedef struct packed {
        logic req;
        logic addr_en;
        logic drive;
        logic wr_n;
        logic step;
        logic done;
        logic busy;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_RESET = '{
        req: 1'b0, addr_en: 1'b0, drive: 1'b0, wr_n: 1'b1,
        step: 1'b0, done: 1'b0, busy: 1'b0
    };

    // States in which a memory cycle owns the address lines
    function automatic logic in_window(input seq_state_t s);
        return (s == S_CYC) || (s == S_GNT);
    endfunction

    // Output decode for a given (next) state
    function automatic bus_ctl_t decode_ctl(input seq_state_t s, input logic is_wr);
        bus_ctl_t c;
        c = CTL_RESET;
        case (s)
            S_CYC: begin
                c.req     = 1'b1;
                c.addr_en = 1'b1;
                c.drive   = is_wr;
                c.wr_n    = ~is_wr;
                c.busy    = 1'b1;
            end
            S_GNT: begin
                c.addr_en = 1'b1;
                c.drive   = is_wr;
                c.wr_n    = ~is_wr;
                c.busy    = 1'b1;
            end
            S_ARM, S_HOST: begin
                c.busy = 1'b1;
            end
            S_POST: begin
                c.step = 1'b1;
                c.busy = 1'b1;
            end
            S_DONE: begin
                c.done = 1'b1;
            end
            default: begin
                c = CTL_RESET;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gxs_xfer_cnt.sv
module gxs_xfer_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             load_is_zero,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] remain_q;

    assign load_is_zero = (load_val == '0);
    assign cnt_zero     = (remain_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec && !cnt_zero) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/gxs_data_regs.sv
module gxs_data_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_cap,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] wr_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
            wr_word <= '0;
        end else begin
            if (rd_cap) begin
                rd_word <= bus_din;
            end
            if (wr_load) begin
                wr_word <= host_din;
            end
        end
    end
endmodule

// File: rtl/gxs_ctrl.sv
module gxs_ctrl
    import gxs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctl_load,
    input  logic     ctl_dir,
    input  logic     load_is_zero,
    input  logic     bus_grant,
    input  logic     host_ack,
    input  logic     cnt_zero,
    output bus_ctl_t ctl_q,
    output logic     cnt_dec,
    output logic     rd_cap_en,
    output logic     wr_load
);
    seq_state_t state_q, state_d;
    logic       dir_q, dir_d;

    always_comb begin
        state_d = state_q;
        dir_d   = dir_q;
        if (ctl_load) begin
            // a new control word always wins, including mid-cycle (abort)
            dir_d   = ctl_dir;
            state_d = load_is_zero ? S_DONE : S_ARM;
        end else begin
            case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_ARM:  state_d = S_CYC;
                S_CYC:  state_d = bus_grant ? S_GNT : S_CYC;
                S_GNT:  state_d = bus_grant ? S_GNT : S_POST;
                S_POST: state_d = cnt_zero ? S_DONE : S_HOST;
                S_HOST: state_d = host_ack ? S_CYC : S_HOST;
                S_DONE: state_d = S_DONE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // count one word when the grant is withdrawn
    assign cnt_dec   = !ctl_load && (state_q == S_GNT) && !bus_grant;
    assign rd_cap_en = !dir_q && in_window(state_q);
    assign wr_load   = ctl_load || ((state_q == S_HOST) && host_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            dir_q   <= 1'b0;
            ctl_q   <= CTL_RESET;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
            ctl_q   <= decode_ctl(state_d, dir_d);
        end
    end
endmodule

// File: rtl/gbus_xfer_seq.sv
module gbus_xfer_seq
    import gxs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_load,
    input  logic              ctl_dir,
    input  logic [CNT_W-1:0]  ctl_count,
    input  logic              host_ack,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              bus_grant,
    input  logic              bus_strobe,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_addr_en,
    output logic              bus_drive,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_word,
    output logic              addr_step,
    output logic              done,
    output logic              busy
);
    bus_ctl_t ctl;
    logic     load_is_zero, cnt_zero, cnt_dec, rd_cap_en, wr_load;

    gxs_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ctl_load     (ctl_load),
        .ctl_dir      (ctl_dir),
        .load_is_zero (load_is_zero),
        .bus_grant    (bus_grant),
        .host_ack     (host_ack),
        .cnt_zero     (cnt_zero),
        .ctl_q        (ctl),
        .cnt_dec      (cnt_dec),
        .rd_cap_en    (rd_cap_en),
        .wr_load      (wr_load)
    );

    gxs_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .load         (ctl_load),
        .load_val     (ctl_count),
        .dec          (cnt_dec),
        .load_is_zero (load_is_zero),
        .cnt_zero     (cnt_zero)
    );

    gxs_data_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rd_cap   (rd_cap_en && bus_strobe),
        .bus_din  (bus_rdata),
        .wr_load  (wr_load),
        .host_din (host_wdata),
        .rd_word  (rd_word),
        .wr_word  (bus_wdata)
    );

    assign bus_req     = ctl.req;
    assign bus_addr_en = ctl.addr_en;
    assign bus_drive   = ctl.drive;
    assign bus_wr_n    = ctl.wr_n;
    assign addr_step   = ctl.step;
    assign done        = ctl.done;
    assign busy        = ctl.busy;
endmodule

// File: rtl/gxs_checker.sv
module gxs_checker (
    input logic clk,
    input logic rst,
    input logic ctl_load,
    input logic bus_grant,
    input logic bus_req,
    input logic bus_addr_en,
    input logic bus_drive,
    input logic bus_wr_n,
    input logic addr_step,
    input logic done,
    input logic busy
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!bus_req && !bus_addr_en && !bus_drive && bus_wr_n && !addr_step && !done && !busy));

    p_req_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_grant) |=> !bus_req);

    p_wr_needs_drive_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> (bus_drive && bus_addr_en));

    p_release_together_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_addr_en) |-> (!bus_drive && bus_wr_n && !bus_req));

    p_step_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        addr_step |=> !addr_step);

    p_no_req_after_step_r7: assert property (@(posedge clk) disable iff (rst)
        addr_step |=> !bus_req);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_req && !bus_addr_en && !busy));

    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_load |=> (!bus_req && !bus_addr_en));
endmodule

bind gbus_xfer_seq gxs_checker u_gxs_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_load    (ctl_load),
    .bus_grant   (bus_grant),
    .bus_req     (bus_req),
    .bus_addr_en (bus_addr_en),
    .bus_drive   (bus_drive),
    .bus_wr_n    (bus_wr_n),
    .addr_step   (addr_step),
    .done        (done),
    .busy        (busy)
);

// File: tb/test_gbus_xfer_seq.sv
`timescale 1ns/1ps
module test_gbus_xfer_seq;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          ctl_load, ctl_dir, host_ack;
    logic [CW-1:0] ctl_count;
    logic [DW-1:0] host_wdata;
    logic          bus_grant, bus_strobe;
    logic [DW-1:0] bus_rdata;
    logic          bus_req, bus_addr_en, bus_drive, bus_wr_n;
    logic [DW-1:0] bus_wdata, rd_word;
    logic          addr_step, done, busy;

    gbus_xfer_seq #(.DATA_W(DW), .CNT_W(CW)) i_gbus_xfer_seq (
        .clk(clk), .rst(rst), .ctl_load(ctl_load), .ctl_dir(ctl_dir),
        .ctl_count(ctl_count), .host_ack(host_ack), .host_wdata(host_wdata),
        .bus_grant(bus_grant), .bus_strobe(bus_strobe), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_addr_en(bus_addr_en), .bus_drive(bus_drive),
        .bus_wr_n(bus_wr_n), .bus_wdata(bus_wdata), .rd_word(rd_word),
        .addr_step(addr_step), .done(done), .busy(busy)
    );

    always #4 clk = ~clk;  // 125 MHz

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] exp_rd[$];
    logic [DW-1:0] exp_wr[$];
    int  addr_ctr = 0;
    int  steps = 0;
    int  served = 0;
    bit  mem_en = 1'b0;
    bit  cur_dir = 1'b0;
    bit  prev_addr_en = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_word(input int a);
        return DW'(32'hA500 ^ (a * 32'h0111));
    endfunction

    function automatic logic [DW-1:0] wr_word_of(input int i);
        return DW'(32'h3C00 + i * 32'h0101);
    endfunction

    // memory model: random latency, then grant; read strobe or write capture
    initial begin
        int lat;
        int hold;
        bus_grant  = 1'b0;
        bus_strobe = 1'b0;
        bus_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_en && bus_req && !rst) begin
                lat = $urandom_range(0, 7);
                repeat (lat) @(negedge clk);
                if (mem_en && bus_req) begin
                    bus_grant = 1'b1;
                    if (bus_wr_n) begin
                        check(!bus_drive, "R4 drive off in read", bus_drive, 0);
                        bus_rdata  = mem_word(addr_ctr);
                        bus_strobe = 1'b1;
                        exp_rd.push_back(mem_word(addr_ctr));
                    end else begin
                        check(bus_drive && bus_addr_en, "R5 drive during write", bus_drive, 1);
                        if (exp_wr.size() == 0) begin
                            check(1'b0, "R5 unexpected write", bus_wdata, 0);
                        end else begin
                            logic [DW-1:0] e;
                            e = exp_wr.pop_front();
                            check(bus_wdata == e, "R5/R11 write word", bus_wdata, e);
                        end
                    end
                    served++;
                    @(negedge clk);
                    bus_strobe = 1'b0;
                    check(!bus_req && bus_addr_en, "R3 request drops after grant",
                          {bus_req, bus_addr_en}, 2'b01);
                    hold = $urandom_range(0, 2);
                    repeat (hold) @(negedge clk);
                    bus_grant = 1'b0;
                end
            end
        end
    end

    // monitor: each address advance closes one transfer
    always @(negedge clk) begin
        if (!rst) begin
            if (addr_step) begin
                steps++;
                check(prev_addr_en && !bus_addr_en && !bus_drive && bus_wr_n,
                      "R6 release together with step",
                      {prev_addr_en, bus_addr_en, bus_drive, bus_wr_n}, 4'b1001);
                if (!cur_dir) begin
                    if (exp_rd.size() == 0) begin
                        check(1'b0, "R4 no read expected", rd_word, 0);
                    end else begin
                        logic [DW-1:0] e;
                        e = exp_rd.pop_front();
                        check(rd_word == e, "R4 read word", rd_word, e);
                    end
                end
                addr_ctr++;
            end
            prev_addr_en = bus_addr_en;
        end
    end

    task automatic start_load(input bit dir, input int n);
        ctl_dir   = dir;
        ctl_count = CW'(n);
        ctl_load  = 1'b1;
        @(negedge clk);
        ctl_load  = 1'b0;
    endtask

    task automatic run_pass(input bit dir, input int n);
        steps    = 0;
        served   = 0;
        addr_ctr = 0;
        cur_dir  = dir;
        exp_rd.delete();
        exp_wr.delete();
        host_wdata = wr_word_of(0);
        if (dir) exp_wr.push_back(wr_word_of(0));
        start_load(dir, n);
        check(!bus_req && busy, "R2 armed, no request yet", {bus_req, busy}, 2'b01);
        @(negedge clk);
        check(bus_req && bus_addr_en, "R2 request on second clock", {bus_req, bus_addr_en}, 2'b11);
        for (int i = 0; i < n; i++) begin
            while (!addr_step) @(negedge clk);
            if (i < n - 1) begin
                int gap;
                gap = $urandom_range(1, 4);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    check(!bus_req && !done, "R7 hold off until host ack", bus_req, 0);
                end
                if (dir) begin
                    host_wdata = wr_word_of(i + 1);
                    exp_wr.push_back(wr_word_of(i + 1));
                end
                host_ack = 1'b1;
                @(negedge clk);
                host_ack = 1'b0;
                check(bus_req, "R7 request after host ack", bus_req, 1);
            end
        end
        @(negedge clk);
        check(done && !busy, "R8 done after last step", {done, busy}, 2'b10);
        repeat (5) begin
            @(negedge clk);
            check(done && !bus_req, "R8 stays done, no request", {done, bus_req}, 2'b10);
        end
        check(steps == n, "R8 step count", steps, n);
        check(served == n, "R8 cycle count", served, n);
    endtask

    initial begin
        rst = 1'b1;
        ctl_load = 1'b0; ctl_dir = 1'b0; ctl_count = '0;
        host_ack = 1'b0; host_wdata = '0;
        repeat (3) @(negedge clk);
        check(!bus_req && !bus_addr_en && !bus_drive && bus_wr_n && !addr_step && !done && !busy,
              "R1 reset state",
              {bus_req, bus_addr_en, bus_drive, bus_wr_n, addr_step, done, busy}, 7'b0001000);
        rst = 1'b0;
        @(negedge clk);
        check(!bus_req && !done && !busy, "R1 idle after reset", {bus_req, done, busy}, 0);
        mem_en = 1'b1;

        run_pass(1'b0, 5);   // read pass
        run_pass(1'b1, 6);   // write pass
        run_pass(1'b0, 1);   // single word
        run_pass(1'b1, 15);  // full count, all ones
        run_pass(1'b0, 15);

        // zero count
        start_load(1'b0, 0);
        check(done && !bus_req && !busy, "R9 zero count done at once", {done, bus_req, busy}, 3'b100);
        repeat (6) begin
            @(negedge clk);
            check(!bus_req && done, "R9 no request for zero count", bus_req, 0);
        end

        // abort while a request is pending
        mem_en = 1'b0;
        cur_dir = 1'b0;
        start_load(1'b0, 3);
        @(negedge clk);
        check(bus_req, "R2 request before abort", bus_req, 1);
        repeat (2) @(negedge clk);
        bus_grant = 1'b1;
        start_load(1'b1, 2);
        check(!bus_req && !bus_addr_en && busy, "R10 abort drops request",
              {bus_req, bus_addr_en, busy}, 3'b001);
        bus_grant = 1'b0;
        @(negedge clk);
        check(bus_req && !bus_wr_n && bus_drive, "R10 new pass starts",
              {bus_req, bus_wr_n, bus_drive}, 3'b101);
        start_load(1'b0, 0);
        check(done && !bus_req && !bus_addr_en, "R10 second abort to done",
              {done, bus_req, bus_addr_en}, 3'b100);
        mem_en = 1'b1;

        run_pass(1'b1, 3);   // restart from done after abort

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule